// File: doc/BRIEF.md
# Flash Command Gate with Unlock Sequencer

This block is the register front end of an on-chip flash array. A byte-wide register port with two addresses lets software unlock the flash controller, choose a page, and start program, page erase or mass erase operations. Address 0 is the command/status location: a write is a command byte, and a read returns the current controller state as a 6-bit code. Address 1 holds the page select byte (page number in bits 6:0, information-block enable in bit 7). After a special command, address 1 holds the sector protect byte instead.

Erase commands only reach the flash macro after a two-byte unlock key. Program requests only reach it when the controller is open and the target address lies in the selected page. An accepted operation produces a one-cycle start pulse, an operation code, the page number and the information-block flag toward the macro. It also holds busy until the macro reports completion. The controller then re-locks itself.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset the status reads 00H, address 1 reads 00H, `prot_mask` is 00H, and `fl_start` and `fl_busy` are low.
- R2: A read of address 0 returns 0 in bits 7:6 and the state code in bits 5:0: locked 000000, first key seen 000001, second key seen 000010, open 000011, protect selected 000100, program 001000, page erase 010000, mass erase 100000.
- R3: In the locked state, command 73H moves to first key seen. From there, 8CH moves to second key seen. From there, a write to address 1 moves to open.
- R4: Any other command byte in the locked or first-key states returns to locked. So does any command byte in the second-key, open or protect-selected states, unless R7 accepts it.
- R5: In the locked state, command 5EH selects the protect register. While it is selected, writes and reads at address 1 use the protect byte (`prot_mask`), and the page select byte is unchanged.
- R6: In every state other than protect-selected and the three busy states, a write to address 1 loads the page select byte. While busy, such a write is ignored.
- R7: In the open state, command 95H starts a page erase (`fl_op`=10, state 010000) and command 63H starts a mass erase (`fl_op`=11, state 100000). `fl_start` is high for exactly the one cycle after the write.
- R8: In the open state, a `pgm_req` starts a program (`fl_op`=01, state 001000) when the page select bit 7 is 1, or when `pgm_addr[15:9]` equals page select bits 6:0. Otherwise no start occurs and the state stays open.
- R9: Commands 95H and 63H and program requests outside the open state produce no start pulse.
- R10: `fl_busy` is high exactly in the busy states. Command writes while busy are ignored. A `fl_done` pulse while busy returns the state to locked.
- R11: `bus_rdata` is 00H whenever `bus_rd` is low.
- R12: `fl_page` and `fl_info` carry page select bits 6:0 and bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_addr | input | 1 | register select: 0 command/status, 1 page/protect |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, combinational while `bus_rd` is high |
| pgm_req | input | 1 | one-cycle program request |
| pgm_addr | input | 16 | byte address of the program request |
| fl_done | input | 1 | completion pulse from the flash macro |
| fl_start | output | 1 | one-cycle operation start |
| fl_op | output | 2 | operation: 01 program, 10 page erase, 11 mass erase |
| fl_page | output | 7 | selected page number |
| fl_info | output | 1 | information-block target flag |
| fl_busy | output | 1 | operation in progress |
| prot_mask | output | 8 | sector protect byte |

## Verification
The hardest states to reach are the ones behind the full unlock sequence. A program request matches only after 73H, 8CH and a page write, in that order, and any stray command byte in between re-locks the controller. Uniform random bytes would almost never get there. The random stimulus therefore draws command bytes mostly from the small set of meaningful values (keys, erase codes, protect code), and half of the program addresses are built from the page the bench model currently holds. Directed sequences then force a busy state and hit it with commands, page writes and program requests.

// File: rtl/flc_pkg.sv
package flc_pkg;

   typedef enum logic [5:0] {
      ST_LOCK   = 6'b000000,
      ST_KEY1   = 6'b000001,
      ST_KEY2   = 6'b000010,
      ST_OPEN   = 6'b000011,
      ST_PROT   = 6'b000100,
      ST_PGM    = 6'b001000,
      ST_PERASE = 6'b010000,
      ST_MERASE = 6'b100000
   } flc_state_t;

   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_PGM    = 2'b01,
      OP_PERASE = 2'b10,
      OP_MERASE = 2'b11
   } flc_op_t;

   function automatic logic is_busy(flc_state_t s);
      return (s == ST_PGM) || (s == ST_PERASE) || (s == ST_MERASE);
   endfunction

endpackage

// File: rtl/flc_seq.sv
module flc_seq
   import flc_pkg::*;
#(
   parameter logic [7:0] KEY_A      = 8'h73,
   parameter logic [7:0] KEY_B      = 8'h8C,
   parameter logic [7:0] PROT_CMD   = 8'h5E,
   parameter logic [7:0] PERASE_CMD = 8'h95,
   parameter logic [7:0] MERASE_CMD = 8'h63
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic       page_wr,
   input  logic       pgm_req,
   input  logic       pgm_hit,
   input  logic       op_done,
   output flc_state_t state_q,
   output logic       start_q,
   output flc_op_t    op_q
);

   flc_state_t state_d;
   logic       start_d;
   flc_op_t    op_d;

   always_comb begin
      state_d = state_q;
      start_d = 1'b0;
      op_d    = op_q;
      unique case (state_q)
         ST_LOCK: if (cmd_wr) begin
            if (cmd_byte == KEY_A)         state_d = ST_KEY1;
            else if (cmd_byte == PROT_CMD) state_d = ST_PROT;
            else                           state_d = ST_LOCK;
         end
         ST_KEY1: if (cmd_wr) state_d = (cmd_byte == KEY_B) ? ST_KEY2 : ST_LOCK;
         ST_KEY2: begin
            if (cmd_wr)       state_d = ST_LOCK;
            else if (page_wr) state_d = ST_OPEN;
         end
         ST_OPEN: begin
            if (cmd_wr) begin
               if (cmd_byte == PERASE_CMD) begin
                  state_d = ST_PERASE; start_d = 1'b1; op_d = OP_PERASE;
               end else if (cmd_byte == MERASE_CMD) begin
                  state_d = ST_MERASE; start_d = 1'b1; op_d = OP_MERASE;
               end else begin
                  state_d = ST_LOCK;
               end
            end else if (pgm_req && pgm_hit) begin
               state_d = ST_PGM; start_d = 1'b1; op_d = OP_PGM;
            end
         end
         ST_PROT: if (cmd_wr) state_d = ST_LOCK;
         ST_PGM, ST_PERASE, ST_MERASE: if (op_done) state_d = ST_LOCK;
         default: state_d = ST_LOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOCK;
         start_q <= 1'b0;
         op_q    <= OP_NONE;
      end else begin
         state_q <= state_d;
         start_q <= start_d;
         op_q    <= op_d;
      end
   end

   assert_start_from_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(state_q) == ST_OPEN);
   assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> is_busy(state_q));
   assert_done_locks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_busy(state_q) && op_done) |=> state_q == ST_LOCK);

endmodule

// File: rtl/flc_regs.sv
module flc_regs #(
   parameter int          REG_W  = 8,
   parameter logic [REG_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             sel_prot,
   input  logic             hold,
   output logic [REG_W-1:0] page_q,
   output logic [REG_W-1:0] prot_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= RST_VAL;
         prot_q <= RST_VAL;
      end else if (wr) begin
         if (sel_prot)   prot_q <= wdata;
         else if (!hold) page_q <= wdata;
      end
   end

   assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(page_q));
   assert_prot_only_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_q) |-> $past(sel_prot));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
   import flc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 512
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   input  logic                  pgm_req,
   input  logic [ADDR_W-1:0]     pgm_addr,
   input  logic                  fl_done,
   output logic                  fl_start,
   output logic [1:0]            fl_op,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] fl_page,
   output logic                  fl_info,
   output logic                  fl_busy,
   output logic [7:0]            prot_mask
);

   localparam int OFS_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFS_W;
   localparam int INFO_B = 7;

   if (PAGE_W < 1 || PAGE_W > INFO_B) begin : g_bad_page_w
      $error("page number must be 1 to 7 bits wide");
   end
   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page_size
      $error("page size must be a power of two");
   end

   flc_state_t state;
   flc_op_t    op;
   logic [7:0] page_r, prot_r;
   logic       cmd_wr, page_wr, hit, busy;

   assign cmd_wr  = bus_wr && !bus_addr;
   assign page_wr = bus_wr &&  bus_addr;
   assign busy    = is_busy(state);

   if (PAGE_W == INFO_B) begin : g_cmp_full
      assign hit = page_r[INFO_B] || (pgm_addr[ADDR_W-1:OFS_W] == page_r[INFO_B-1:0]);
   end else begin : g_cmp_part
      assign hit = page_r[INFO_B] ||
                   (pgm_addr[ADDR_W-1:OFS_W] == page_r[PAGE_W-1:0] &&
                    page_r[INFO_B-1:PAGE_W] == '0);
   end

   flc_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_byte (bus_wdata),
      .page_wr  (page_wr),
      .pgm_req  (pgm_req),
      .pgm_hit  (hit),
      .op_done  (fl_done),
      .state_q  (state),
      .start_q  (fl_start),
      .op_q     (op)
   );

   flc_regs #(.REG_W(8)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (page_wr),
      .wdata    (bus_wdata),
      .sel_prot (state == ST_PROT),
      .hold     (busy),
      .page_q   (page_r),
      .prot_q   (prot_r)
   );

   always_comb begin
      if (!bus_rd)        bus_rdata = 8'h00;
      else if (!bus_addr) bus_rdata = {2'b00, state};
      else if (state == ST_PROT) bus_rdata = prot_r;
      else                bus_rdata = page_r;
   end

   assign fl_op     = op;
   assign fl_page   = page_r[PAGE_W-1:0];
   assign fl_info   = page_r[INFO_B];
   assign fl_busy   = busy;
   assign prot_mask = prot_r;

   assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == 8'h00);
   assert_busy_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fl_busy |=> !fl_start);

endmodule

// File: tb/flash_cmd_front_tb_top.sv
module flash_cmd_front_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        pgm_req = 1'b0;
   logic [15:0] pgm_addr = 16'h0000;
   logic        fl_done = 1'b0;
   logic        fl_start, fl_info, fl_busy;
   logic [1:0]  fl_op;
   logic [6:0]  fl_page;
   logic [7:0]  prot_mask;

   int checks = 0;
   int errors = 0;

   logic [5:0] m_st = 6'h00;
   logic [7:0] m_pg = 8'h00;
   logic [7:0] m_pr = 8'h00;
   logic       e_start;
   logic [1:0] e_op;

   always #4 clk = ~clk;

   flash_cmd_front dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pgm_req(pgm_req), .pgm_addr(pgm_addr),
      .fl_done(fl_done), .fl_start(fl_start), .fl_op(fl_op), .fl_page(fl_page),
      .fl_info(fl_info), .fl_busy(fl_busy), .prot_mask(prot_mask)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic m_busy();
      return m_st >= 6'h08;
   endfunction

   task automatic check_start(string req);
      chk(req, {15'd0, fl_start}, {15'd0, e_start});
      if (e_start) chk(req, {14'd0, fl_op}, {14'd0, e_op});
      chk("R10 busy", {15'd0, fl_busy}, {15'd0, m_busy()});
   endtask

   task automatic ctl(logic [7:0] v);
      @(negedge clk); bus_addr = 1'b0; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      e_start = 1'b0; e_op = 2'b00;
      case (m_st)
         6'h00: m_st = (v == 8'h73) ? 6'h01 : (v == 8'h5E) ? 6'h04 : 6'h00;
         6'h01: m_st = (v == 8'h8C) ? 6'h02 : 6'h00;
         6'h03: begin
            if (v == 8'h95)      begin m_st = 6'h10; e_start = 1'b1; e_op = 2'b10; end
            else if (v == 8'h63) begin m_st = 6'h20; e_start = 1'b1; e_op = 2'b11; end
            else m_st = 6'h00;
         end
         6'h08, 6'h10, 6'h20: ;
         default: m_st = 6'h00;
      endcase
      check_start("R7/R9 start after command");
   endtask

   task automatic pgw(logic [7:0] v);
      @(negedge clk); bus_addr = 1'b1; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      e_start = 1'b0;
      if (m_st == 6'h04) m_pr = v;
      else if (!m_busy()) begin
         m_pg = v;
         if (m_st == 6'h02) m_st = 6'h03;
      end
      check_start("R6 no start on page write");
   endtask

   task automatic pgm(logic [15:0] a);
      @(negedge clk); pgm_addr = a; pgm_req = 1'b1;
      @(negedge clk); pgm_req = 1'b0;
      e_start = 1'b0; e_op = 2'b01;
      if (m_st == 6'h03 && (m_pg[7] || a[15:9] == m_pg[6:0])) begin
         m_st = 6'h08; e_start = 1'b1;
      end
      check_start("R8/R9 program start");
   endtask

   task automatic done();
      @(negedge clk); fl_done = 1'b1;
      @(negedge clk); fl_done = 1'b0;
      e_start = 1'b0;
      if (m_busy()) m_st = 6'h00;
      check_start("R10 done");
   endtask

   task automatic rd(logic a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic verify_all();
      logic [7:0] d;
      rd(1'b0, d); chk("R2 status", {8'd0, d}, {10'd0, m_st});
      rd(1'b1, d); chk("R5/R6 addr1 read", {8'd0, d}, {8'd0, (m_st == 6'h04) ? m_pr : m_pg});
      chk("R5 prot_mask", {8'd0, prot_mask}, {8'd0, m_pr});
      chk("R12 page/info", {8'd0, fl_info, fl_page}, {8'd0, m_pg});
      #1 chk("R11 idle rdata", {8'd0, bus_rdata}, 16'h0000);
   endtask

   task automatic unlock(logic [7:0] page);
      ctl(8'h73); ctl(8'h8C); pgw(page);
   endtask

   initial begin
      #4000000;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(1'b0, d); chk("R1 reset status", {8'd0, d}, 16'h0000);
      rd(1'b1, d); chk("R1 reset page", {8'd0, d}, 16'h0000);
      chk("R1 reset prot", {8'd0, prot_mask}, 16'h0000);
      chk("R1 reset start/busy", {14'd0, fl_start, fl_busy}, 16'h0000);

      // R3 key sequence with intermediate codes, R2 encodings
      ctl(8'h73); verify_all();
      ctl(8'h8C); verify_all();
      pgw(8'h05); verify_all();
      // R4 stray byte in open state relocks
      ctl(8'h11); verify_all();
      // R4 broken key
      ctl(8'h73); ctl(8'h8D); verify_all();
      // R9 erase while locked: no start
      ctl(8'h95); verify_all();
      pgm(16'h0A00); verify_all();
      // R5 protect selection
      ctl(8'h5E); pgw(8'hC3); verify_all();
      ctl(8'h00); verify_all();
      // R7 page erase, busy ignores commands and page writes (R10, R6)
      unlock(8'h07); ctl(8'h95); ctl(8'h73); pgw(8'h44); pgm(16'h0E00); verify_all();
      done(); verify_all();
      // R7 mass erase
      unlock(8'h02); ctl(8'h63); verify_all(); done(); verify_all();
      // R8 program mismatch then match
      unlock(8'h03); pgm(16'h0800); verify_all();
      pgm(16'h07FE); verify_all(); done();
      // R8 info block program ignores page match
      unlock(8'h81); pgm(16'hFFFF); verify_all(); done(); verify_all();

      // random phase
      for (int i = 0; i < 600; i++) begin
         int k = $urandom_range(0, 9);
         case (k)
            0, 1, 2: begin
               logic [7:0] set [6] = '{8'h73, 8'h8C, 8'h5E, 8'h95, 8'h63, 8'h00};
               int j = $urandom_range(0, 6);
               ctl((j == 6) ? 8'($urandom) : set[j]);
            end
            3: pgw(8'($urandom));
            4: unlock(8'($urandom));
            5, 6: begin
               logic [15:0] a = 16'($urandom);
               if ($urandom_range(0, 1) == 1) a[15:9] = m_pg[6:0];
               pgm(a);
            end
            7: done();
            default: verify_all();
         endcase
      end
      verify_all();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule